// File: doc/BRIEF.md
# NAND Multi-Plane Page Program Sequencer

This block sits on the host side of a NAND flash and programs one page in each of up to four planes in a single operation. A request carries a plane count and, for each slot, a plane index, a block number and a page number. Before any bus traffic starts, the block checks the request. The plane count must be between one and four. No plane may appear twice. Every active slot must select the same page within its block. A request that fails this check is rejected at once, with an error flag.

For an accepted request the slots are loaded in the order given, whatever the plane indices are. Each load is a setup command, five address cycles and the page data. The data comes from a valid/ready byte stream. Every load except the last closes with an intermediate confirm. The last load closes with the command that starts programming. The block then waits for ready/busy to fall and rise again, guarded by a timeout. It issues a status-read command and a single read strobe, and reports the result with a one-cycle done pulse. The result is an overall pass/fail bit and a per-plane fail vector.

Top module: `nand_mp_prog`

## Requirements
- R1: Each slot's load is the setup command 80h, then five address cycles, then PAGE_BYTES data bytes. The address cycles are two column bytes of 00h followed by three row bytes, least significant first. The row word has the page in bits 4:0, the plane in bits 6:5 and the block in bits 17:7, with the upper bits zero. Slots are loaded in request order: slot k takes plane bits [2k+1:2k], block bits [11k+10:11k] and page bits [5k+4:5k].
- R2: Every load except the last ends with command 11h. The last load ends with command 10h.
- R3: If any two active slots select different pages, the request is rejected. The done and request-error pulses are raised in the cycle after the request, and no write strobe occurs. Inactive slots are not compared.
- R4: A plane count of 0 or above 4, or a plane index repeated among the active slots, is rejected in the same way as R3.
- R5: Plane indices may be given in any order, for example 3, 0, 2, 1.
- R6: After 10h, the block waits for ready/busy to go low and then high. It then issues command 71h and exactly one read strobe.
- R7: From the status byte, pass_o is the inverse of bit 0. fail_vec_o[p] is bit p+1, which is the fail flag for plane p.
- R8: If ready/busy has not completed its low-then-high cycle within TIMEOUT_CYCLES after 10h, the block raises done with err_timeout_o. In that case pass_o is 0, and neither 71h nor a read strobe is issued.
- R9: A command cycle has CLE=1 and ALE=0. An address cycle has ALE=1 and CLE=0. A data cycle has both low. Each cycle carries a single-cycle write strobe. The read strobe never coincides with a write strobe.
- R10: After reset, busy_o, done_o, wready_o and all strobes are low.
- R11: A data byte is taken only when wvalid_i and wready_o are both high. Gaps in wvalid_i pause the load without losing or repeating bytes.
- R12: A request presented while busy_o is high is ignored. It raises no error and does not alter the bus traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe, taken when idle |
| req_nplanes_i | input | 3 | Number of active slots |
| req_plane_i | input | 8 | Plane index per slot, 2 bits each |
| req_block_i | input | 44 | Block number per slot, 11 bits each |
| req_page_i | input | 20 | Page number per slot, 5 bits each |
| busy_o | output | 1 | Operation in progress |
| wdata_i | input | 8 | Page data byte |
| wvalid_i | input | 1 | Data byte valid |
| wready_o | output | 1 | Data byte accepted when valid |
| nand_io_o | output | 8 | Flash I/O bus, driven |
| nand_io_i | input | 8 | Flash I/O bus, read |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_o | output | 1 | Write strobe, one cycle per byte |
| nand_re_o | output | 1 | Read strobe |
| nand_rb_i | input | 1 | Ready/busy, low while busy |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Overall program pass |
| fail_vec_o | output | 4 | Per-plane fail flags |
| err_req_o | output | 1 | Request rejected |
| err_timeout_o | output | 1 | Ready/busy timeout |

## Verification
The main function is driven with several request patterns. The first is a single plane, which shows that the first load is also closed with 10h. The second is four planes in ascending order, with a corner block number. The third is four planes in a scrambled order, which shows that the slot order decides the bus order rather than the plane index. The fourth is two planes whose unused slots hold clashing values, which shows that only active slots are compared. Patterns with the data stream stalling are compared against ones without, to show that the byte sequence does not depend on handshake gaps. Invalid plane counts, duplicate planes and page mismatches are each shown to produce no bus cycles. Status bytes with different fail bits tell the per-plane vector apart from the overall flag.

// File: rtl/nand_mp_pkg.sv
package nand_mp_pkg;
  localparam int PLANES      = 4;
  localparam int PLANE_W     = 2;
  localparam int BLOCK_W     = 11;
  localparam int PAGE_W      = 5;
  localparam int NCNT_W      = 3;
  localparam int ADDR_CYCLES = 5;
  localparam int ROW_W       = 24;

  localparam logic [7:0] CMD_SETUP = 8'h80;
  localparam logic [7:0] CMD_NEXT  = 8'h11;
  localparam logic [7:0] CMD_GO    = 8'h10;
  localparam logic [7:0] CMD_STAT  = 8'h71;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SETUP, ST_ADDR, ST_DATA, ST_CONF,
    ST_WAIT_LO, ST_WAIT_HI, ST_STAT, ST_RD, ST_CAP
  } state_e;

  typedef enum logic [1:0] {BUS_NONE, BUS_CMD, BUS_ADDR, BUS_DATA} bus_kind_e;

  typedef struct packed {
    bus_kind_e  kind;
    logic [7:0] val;
    logic       rd;
  } bus_cyc_t;
endpackage

// File: rtl/nand_req_check.sv
module nand_req_check
  import nand_mp_pkg::*;
#(
  parameter int N_PL  = PLANES,
  parameter int PL_W  = PLANE_W,
  parameter int PG_W  = PAGE_W,
  parameter int N_W   = NCNT_W
) (
  input  logic [N_W-1:0]       nplanes_i,
  input  logic [N_PL*PL_W-1:0] plane_i,
  input  logic [N_PL*PG_W-1:0] page_i,
  output logic                 ok_o
);
  logic [N_PL-1:0][N_PL-1:0] clash;

  for (genvar i = 0; i < N_PL; i++) begin : g_i
    for (genvar j = 0; j < N_PL; j++) begin : g_j
      if (j > i) begin : g_pair
        assign clash[i][j] = (N_W'(i) < nplanes_i) && (N_W'(j) < nplanes_i) &&
                             ((plane_i[i*PL_W +: PL_W] == plane_i[j*PL_W +: PL_W]) ||
                              (page_i[i*PG_W +: PG_W]  != page_i[j*PG_W +: PG_W]));
      end else begin : g_none
        assign clash[i][j] = 1'b0;
      end
    end
  end

  assign ok_o = (nplanes_i != '0) && (nplanes_i <= N_W'(N_PL)) && (clash == '0);

  // R4: an accepted count is always in range
  always_comb begin
    assert_count_range_R4: assert (!ok_o || (nplanes_i >= N_W'(1) && nplanes_i <= N_W'(N_PL)));
  end
endmodule

// File: rtl/nand_rb_timer.sv
module nand_rb_timer #(
  parameter int LIMIT = 4096,
  localparam int CW   = $clog2(LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic expired_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (clr_i)                     cnt_q <= '0;
    else if (en_i && cnt_q != CW'(LIMIT)) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = en_i && (cnt_q == CW'(LIMIT));

  assert_expire_while_waiting_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(expired_o) |-> $past(en_i));
endmodule

// File: rtl/nand_bus_drv.sv
module nand_bus_drv
  import nand_mp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  bus_cyc_t   cyc_i,
  output logic [7:0] io_o,
  output logic       cle_o,
  output logic       ale_o,
  output logic       we_o,
  output logic       re_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      io_o <= '0; cle_o <= 1'b0; ale_o <= 1'b0; we_o <= 1'b0; re_o <= 1'b0;
    end else begin
      io_o  <= cyc_i.val;
      cle_o <= (cyc_i.kind == BUS_CMD);
      ale_o <= (cyc_i.kind == BUS_ADDR);
      we_o  <= (cyc_i.kind != BUS_NONE);
      re_o  <= cyc_i.rd;
    end
  end

  assert_latch_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cle_o && ale_o));
  assert_rd_wr_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(re_o && we_o));
endmodule

// File: rtl/nand_mp_prog.sv
module nand_mp_prog
  import nand_mp_pkg::*;
#(
  parameter int PAGE_BYTES     = 16,
  parameter int TIMEOUT_CYCLES = 4096,
  localparam int CNT_MAX       = (PAGE_BYTES > ADDR_CYCLES) ? PAGE_BYTES : ADDR_CYCLES,
  localparam int CNT_W         = $clog2(CNT_MAX),
  localparam int SLOT_W        = $clog2(PLANES)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_valid_i,
  input  logic [NCNT_W-1:0]         req_nplanes_i,
  input  logic [PLANES*PLANE_W-1:0] req_plane_i,
  input  logic [PLANES*BLOCK_W-1:0] req_block_i,
  input  logic [PLANES*PAGE_W-1:0]  req_page_i,
  output logic                      busy_o,
  input  logic [7:0]                wdata_i,
  input  logic                      wvalid_i,
  output logic                      wready_o,
  output logic [7:0]                nand_io_o,
  input  logic [7:0]                nand_io_i,
  output logic                      nand_cle_o,
  output logic                      nand_ale_o,
  output logic                      nand_we_o,
  output logic                      nand_re_o,
  input  logic                      nand_rb_i,
  output logic                      done_o,
  output logic                      pass_o,
  output logic [PLANES-1:0]         fail_vec_o,
  output logic                      err_req_o,
  output logic                      err_timeout_o
);
  state_e state_q, state_d;
  logic [SLOT_W-1:0] slot_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [NCNT_W-1:0] n_q;
  logic [PLANE_W-1:0] plane_q [PLANES];
  logic [BLOCK_W-1:0] block_q [PLANES];
  logic [PAGE_W-1:0]  page_q;
  logic req_ok, last_slot, tmr_exp, tmr_en, tmr_clr;
  logic [ROW_W-1:0] row;
  bus_cyc_t cyc;
  logic unused_status;

  assign unused_status = ^nand_io_i[7:PLANES+1];

  nand_req_check u_check (
    .nplanes_i (req_nplanes_i),
    .plane_i   (req_plane_i),
    .page_i    (req_page_i),
    .ok_o      (req_ok)
  );

  nand_rb_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (tmr_clr),
    .en_i      (tmr_en),
    .expired_o (tmr_exp)
  );

  nand_bus_drv u_bus (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cyc_i (cyc),
    .io_o  (nand_io_o),
    .cle_o (nand_cle_o),
    .ale_o (nand_ale_o),
    .we_o  (nand_we_o),
    .re_o  (nand_re_o)
  );

  assign last_slot = ({1'b0, slot_q} == n_q - NCNT_W'(1));
  assign row       = ROW_W'({block_q[slot_q], plane_q[slot_q], page_q});
  assign busy_o    = (state_q != ST_IDLE);
  assign wready_o  = (state_q == ST_DATA);
  assign tmr_en    = (state_q == ST_WAIT_LO) || (state_q == ST_WAIT_HI);
  assign tmr_clr   = (state_q == ST_CONF);

  always_comb begin
    state_d  = state_q;
    cyc      = '{kind: BUS_NONE, val: 8'h00, rd: 1'b0};
    unique case (state_q)
      ST_IDLE:  if (req_valid_i && req_ok) state_d = ST_SETUP;
      ST_SETUP: begin
        cyc     = '{kind: BUS_CMD, val: CMD_SETUP, rd: 1'b0};
        state_d = ST_ADDR;
      end
      ST_ADDR: begin
        cyc.kind = BUS_ADDR;
        case (cnt_q)
          CNT_W'(2): cyc.val = row[7:0];
          CNT_W'(3): cyc.val = row[15:8];
          CNT_W'(4): cyc.val = row[23:16];
          default:   cyc.val = 8'h00;
        endcase
        if (cnt_q == CNT_W'(ADDR_CYCLES - 1)) state_d = ST_DATA;
      end
      ST_DATA: if (wvalid_i) begin
        cyc = '{kind: BUS_DATA, val: wdata_i, rd: 1'b0};
        if (cnt_q == CNT_W'(PAGE_BYTES - 1)) state_d = ST_CONF;
      end
      ST_CONF: begin
        cyc     = '{kind: BUS_CMD, val: last_slot ? CMD_GO : CMD_NEXT, rd: 1'b0};
        state_d = last_slot ? ST_WAIT_LO : ST_SETUP;
      end
      ST_WAIT_LO: if (tmr_exp) state_d = ST_IDLE;
                  else if (!nand_rb_i) state_d = ST_WAIT_HI;
      ST_WAIT_HI: if (tmr_exp) state_d = ST_IDLE;
                  else if (nand_rb_i) state_d = ST_STAT;
      ST_STAT: begin
        cyc     = '{kind: BUS_CMD, val: CMD_STAT, rd: 1'b0};
        state_d = ST_RD;
      end
      ST_RD: begin
        cyc.rd  = 1'b1;
        state_d = ST_CAP;
      end
      ST_CAP:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
      cnt_q   <= '0;
      n_q     <= '0;
      page_q  <= '0;
      for (int k = 0; k < PLANES; k++) begin
        plane_q[k] <= '0;
        block_q[k] <= '0;
      end
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && req_valid_i && req_ok) begin
        n_q    <= req_nplanes_i;
        page_q <= req_page_i[PAGE_W-1:0];
        slot_q <= '0;
        for (int k = 0; k < PLANES; k++) begin
          plane_q[k] <= req_plane_i[k*PLANE_W +: PLANE_W];
          block_q[k] <= req_block_i[k*BLOCK_W +: BLOCK_W];
        end
      end
      if (state_q == ST_CONF && !last_slot) slot_q <= slot_q + 1'b1;
      if (state_d != state_q)                     cnt_q <= '0;
      else if (state_q == ST_ADDR)                cnt_q <= cnt_q + 1'b1;
      else if (state_q == ST_DATA && wvalid_i)    cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0; pass_o <= 1'b0; fail_vec_o <= '0;
      err_req_o <= 1'b0; err_timeout_o <= 1'b0;
    end else begin
      done_o <= 1'b0; err_req_o <= 1'b0; err_timeout_o <= 1'b0;
      if (state_q == ST_IDLE && req_valid_i && !req_ok) begin
        done_o <= 1'b1; err_req_o <= 1'b1; pass_o <= 1'b0; fail_vec_o <= '0;
      end else if (tmr_exp) begin
        done_o <= 1'b1; err_timeout_o <= 1'b1; pass_o <= 1'b0; fail_vec_o <= '0;
      end else if (state_q == ST_CAP) begin
        done_o     <= 1'b1;
        pass_o     <= !nand_io_i[0];
        fail_vec_o <= nand_io_i[PLANES:1];
      end
    end
  end

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_reject_no_bus_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_req_o |-> (!nand_we_o && !busy_o));
  assert_go_on_last_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nand_we_o && nand_cle_o && nand_io_o == CMD_GO) |-> last_slot);
  assert_ready_when_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wready_o |-> busy_o);
  assert_timeout_no_pass_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_timeout_o |-> (done_o && !pass_o));
endmodule

// File: tb/nand_mp_prog_test.sv
module nand_mp_prog_test;
  localparam int PB = 6;
  localparam int TO = 300;
  localparam int NV = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req_valid = 0;
  logic [2:0]  req_n = 0;
  logic [7:0]  req_pl = 0;
  logic [43:0] req_bk = 0;
  logic [19:0] req_pg = 0;
  logic        busy, wready, wvalid = 0;
  logic [7:0]  wdata = 0, io_o, io_i = 0;
  logic        cle, ale, we, re, rb = 1;
  logic        done, pass, err_req, err_to;
  logic [3:0]  fvec;

  nand_mp_prog #(.PAGE_BYTES(PB), .TIMEOUT_CYCLES(TO)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_nplanes_i(req_n),
    .req_plane_i(req_pl), .req_block_i(req_bk), .req_page_i(req_pg), .busy_o(busy),
    .wdata_i(wdata), .wvalid_i(wvalid), .wready_o(wready), .nand_io_o(io_o),
    .nand_io_i(io_i), .nand_cle_o(cle), .nand_ale_o(ale), .nand_we_o(we),
    .nand_re_o(re), .nand_rb_i(rb), .done_o(done), .pass_o(pass),
    .fail_vec_o(fvec), .err_req_o(err_req), .err_timeout_o(err_to));

  localparam logic [2:0]  V_N   [NV] = '{3'd1, 3'd4, 3'd4, 3'd2, 3'd3, 3'd0, 3'd5, 3'd2};
  localparam logic [7:0]  V_PL  [NV] = '{8'h02, 8'hE4, 8'h63, 8'h0D, 8'h28, 8'h00, 8'hE4, 8'h22};
  localparam logic [43:0] V_BK  [NV] = '{44'd5,
                                        {11'd2047, 11'd0, 11'd1, 11'd1024},
                                        {11'd9, 11'd8, 11'd7, 11'd6},
                                        {11'd0, 11'd0, 11'd3, 11'd4},
                                        {11'd0, 11'd1, 11'd2, 11'd3},
                                        44'd0, {11'd1, 11'd2, 11'd3, 11'd4},
                                        {11'd0, 11'd0, 11'd100, 11'd200}};
  localparam logic [19:0] V_PG  [NV] = '{20'd3, {4{5'd7}}, {4{5'd31}},
                                        {5'd0, 5'd0, 5'd4, 5'd5}, {4{5'd2}}, 20'd0,
                                        {4{5'd1}}, {5'd1, 5'd0, 5'd16, 5'd16}};
  localparam logic [7:0]  V_ST  [NV] = '{8'h00, 8'h00, 8'h0B, 8'h00, 8'h00, 8'h00, 8'h00, 8'h11};
  localparam logic        V_STL [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
  localparam logic        V_ERR [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};

  int n_chk = 0, n_bad = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bus log and responder
  logic [1:0] lg_k [256];
  logic [7:0] lg_v [256];
  int lg_n = 0, re_n = 0, rb_cnt = 0, rb_low = 20;
  bit got_done = 0, got_err = 0, got_to = 0, got_pass = 0;
  logic [3:0] got_fv = 0;
  int tick = 0, src = 0;
  bit stall = 0;

  always @(negedge clk) begin
    tick++;
    if (we && lg_n < 256) begin
      lg_k[lg_n] = cle ? 2'd1 : (ale ? 2'd2 : 2'd3);
      lg_v[lg_n] = io_o;
      lg_n++;
      if (cle && io_o == 8'h10) rb_cnt = rb_low;
    end
    if (re) re_n++;
    if (rb_cnt > 0) begin rb = 0; rb_cnt--; end else rb = 1;
    if (done) begin
      got_done = 1; got_err = err_req; got_to = err_to; got_pass = pass; got_fv = fvec;
    end
    wvalid = stall ? tick[1] : 1'b1;
    wdata  = 8'(src);
    if (wvalid && wready) src++;
  end

  logic [1:0] ex_k [256];
  logic [7:0] ex_v [256];
  int ex_n;

  task automatic build_exp(input logic [2:0] n, input logic [7:0] pl, input logic [43:0] bk,
                           input logic [19:0] pg, input int seed, input bit stat);
    int d = seed;
    ex_n = 0;
    for (int s = 0; s < int'(n); s++) begin
      logic [23:0] row = {6'd0, bk[s*11 +: 11], pl[s*2 +: 2], pg[4:0]};
      ex_k[ex_n] = 1; ex_v[ex_n] = 8'h80; ex_n++;
      for (int a = 0; a < 5; a++) begin
        ex_k[ex_n] = 2;
        ex_v[ex_n] = (a < 2) ? 8'h00 : row[(a-2)*8 +: 8];
        ex_n++;
      end
      for (int b = 0; b < PB; b++) begin ex_k[ex_n] = 3; ex_v[ex_n] = 8'(d); d++; ex_n++; end
      ex_k[ex_n] = 1; ex_v[ex_n] = (s == int'(n) - 1) ? 8'h10 : 8'h11; ex_n++;
    end
    if (stat) begin ex_k[ex_n] = 1; ex_v[ex_n] = 8'h71; ex_n++; end
  endtask

  task automatic cmp_log(input string tag);
    int bad = -1;
    chk(lg_n == ex_n, {tag, " bus cycle count"}, lg_n, ex_n);
    for (int i = 0; i < ex_n && i < lg_n; i++)
      if (bad < 0 && (lg_k[i] != ex_k[i] || lg_v[i] != ex_v[i])) bad = i;
    chk(bad < 0, {tag, " bus cycle content"}, (bad < 0) ? 0 : {lg_k[bad], lg_v[bad]},
        (bad < 0) ? 0 : {ex_k[bad], ex_v[bad]});
  endtask

  task automatic start(input logic [2:0] n, input logic [7:0] pl, input logic [43:0] bk,
                       input logic [19:0] pg, input int seed);
    @(negedge clk);
    lg_n = 0; re_n = 0; got_done = 0; src = seed;
    req_n = n; req_pl = pl; req_bk = bk; req_pg = pg; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_done(output bit ok);
    int w = 0;
    while (!got_done && w < 5000) begin @(negedge clk); w++; end
    ok = got_done;
    chk(ok, "watchdog: done pulse seen", 0, 1);
  endtask

  initial begin
    bit ok;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!busy && !done && !wready, "R10 idle outputs after reset", {busy, done, wready}, 0);
    chk(!we && !re && !cle && !ale, "R10 strobes low after reset", {we, re, cle, ale}, 0);
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      string tag;
      tag = V_ERR[v] ? $sformatf("R3/R4 vec%0d", v) : $sformatf("R1/R2/R5/R6/R11 vec%0d", v);
      io_i = V_ST[v]; stall = V_STL[v]; rb_low = 20;
      start(V_N[v], V_PL[v], V_BK[v], V_PG[v], v * 16);
      wait_done(ok);
      if (V_ERR[v]) begin
        chk(got_err, {tag, " request error flagged"}, got_err, 1);
        chk(lg_n == 0 && !busy, {tag, " no bus cycles on reject"}, lg_n, 0);
      end else begin
        build_exp(V_N[v], V_PL[v], V_BK[v], V_PG[v], v * 16, 1);
        cmp_log(tag);
        chk(re_n == 1, $sformatf("R6 vec%0d one read strobe", v), re_n, 1);
        chk(got_pass == !V_ST[v][0], $sformatf("R7 vec%0d pass", v), got_pass, !V_ST[v][0]);
        chk(got_fv == V_ST[v][4:1], $sformatf("R7 vec%0d fail vector", v), got_fv, V_ST[v][4:1]);
        chk(!got_err && !got_to, $sformatf("R7 vec%0d no error flags", v), {got_err, got_to}, 0);
      end
      repeat (4) @(negedge clk);
    end

    // R8 timeout: ready/busy held low past the limit
    stall = 0; io_i = 8'h00; rb_low = TO + 200;
    start(3'd1, 8'h01, 44'd77, 20'd9, 200);
    wait_done(ok);
    build_exp(3'd1, 8'h01, 44'd77, 20'd9, 200, 0);
    cmp_log("R8 timeout");
    chk(got_to && !got_pass, "R8 timeout flag and no pass", {got_to, got_pass}, 2);
    chk(re_n == 0, "R8 no status read after timeout", re_n, 0);
    rb_cnt = 0;
    repeat (4) @(negedge clk);

    // R12 request while busy is ignored
    rb_low = 20; io_i = 8'h00;
    start(3'd1, 8'h03, 44'd12, 20'd4, 40);
    repeat (3) @(negedge clk);
    req_n = 3'd0; req_pl = 8'hE4; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    wait_done(ok);
    chk(!got_err, "R12 no error from request while busy", got_err, 0);
    build_exp(3'd1, 8'h03, 44'd12, 20'd4, 40, 1);
    cmp_log("R12 busy request");
    repeat (10) @(negedge clk);
    chk(!busy && lg_n == ex_n, "R12 no second operation", lg_n, ex_n);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule